// File: doc/BRIEF.md
# Packed-Lane Add/Subtract Unit

This unit performs one add or subtract across a 64-bit operand pair that holds packed integer lanes. A select picks the lane width: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane is computed independently. The carry chain is broken at each lane edge, so no lane's result depends on a neighbouring lane.

A lane result can wrap modulo its width. It can also clamp to the limits of its range, read either as a two's-complement signed value or as an unsigned value. The result goes into a register on a cycle where the input strobe is high. An output strobe marks the cycle after that update.

Top module: `psimd_alu`

## Requirements
- R1: `lane_sel_i` encodes the lane width: 0 gives 8-bit lanes (8 lanes), 1 gives 16-bit lanes (4 lanes), and both 2 and 3 give 32-bit lanes (2 lanes). Lane k occupies bits [k*w+w-1 : k*w].
- R2: No carry or borrow crosses a lane boundary for the selected width.
- R3: With `sat_i`=0 and `sub_i`=0, each lane is (a+b) mod 2^w.
- R4: With `sub_i`=1, each lane computes a-b (in wrap mode, (a-b) mod 2^w).
- R5: With `sat_i`=1 and `sat_signed_i`=1, a lane whose signed result overflows becomes 0x7F..F when the true result is above the maximum and 0x80..0 when it is below the minimum.
- R6: With `sat_i`=1, `sat_signed_i`=0 and `sub_i`=0, an unsigned add that exceeds 2^w-1 gives all ones in that lane.
- R7: With `sat_i`=1, `sat_signed_i`=0 and `sub_i`=1, an unsigned subtract with a<b gives zero in that lane.
- R8: In either saturating mode, a lane that does not overflow gives the same value as wrap mode.
- R9: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid` high.
- R10: `res_o` changes only on a clock edge where `in_valid` is high. Inputs applied while `in_valid` is low have no effect.
- R11: After reset, `res_o` is 0 and `out_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands valid; loads the result register |
| a_i | input | 64 | First packed operand |
| b_i | input | 64 | Second packed operand (subtrahend) |
| lane_sel_i | input | 2 | Lane width select (R1) |
| sub_i | input | 1 | 0 add, 1 subtract |
| sat_i | input | 1 | 0 wrap, 1 saturate |
| sat_signed_i | input | 1 | Saturation reads lanes as signed when 1 |
| res_o | output | 64 | Registered packed result |
| out_valid_o | output | 1 | Result updated in the previous cycle |

## Verification
The bench targets lane edges. It uses patterns like 0x00FF plus 1, which is zero at 8-bit width and 0x0100 at 16-bit width. A chain that fails to cut at the edges would leak a carry into the next lane. A chain that cuts at the wrong width would drop a carry inside a lane.

Saturation is checked on both sides of every limit. A design that takes the clamp direction from the result sign, rather than the operand sign, would return the wrong extreme. Confusing the borrow sense of an unsigned subtract would clamp non-underflowing lanes to zero.

Inputs are also changed while the strobe is low. This catches a register that loads without the strobe.

// File: rtl/psimd_pkg.sv
package psimd_pkg;
    typedef enum logic [1:0] {
        LANE8   = 2'd0,
        LANE16  = 2'd1,
        LANE32  = 2'd2,
        LANE32X = 2'd3
    } lane_sel_e;
endpackage

// File: rtl/psimd_segadd.sv
module psimd_segadd
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0]        a,
    input  logic [DATA_W-1:0]        b,
    input  lane_sel_e                lane_sel,
    input  logic                     sub,
    output logic [DATA_W-1:0]        sum,
    output logic [DATA_W/BYTE_W-1:0] byte_cout,
    output logic [DATA_W/BYTE_W-1:0] byte_ovf,
    output logic [DATA_W/BYTE_W-1:0] byte_aneg
);
    localparam int NB = DATA_W / BYTE_W;

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam bit START16 = (i % 2) == 0;
        localparam bit START32 = (i % 4) == 0;
        logic              seg_start;
        logic              cin;
        logic [BYTE_W-1:0] a_b;
        logic [BYTE_W-1:0] b_x;
        logic [BYTE_W:0]   ext;

        assign a_b = a[i*BYTE_W +: BYTE_W];
        assign b_x = b[i*BYTE_W +: BYTE_W] ^ {BYTE_W{sub}};

        always_comb begin
            case (lane_sel)
                LANE8:   seg_start = 1'b1;
                LANE16:  seg_start = START16;
                default: seg_start = START32;
            endcase
        end

        if (i == 0) begin : g_first
            assign cin = sub;
        end else begin : g_rest
            assign cin = seg_start ? sub : byte_cout[i-1];
        end

        assign ext = {1'b0, a_b} + {1'b0, b_x} + {{BYTE_W{1'b0}}, cin};
        assign sum[i*BYTE_W +: BYTE_W] = ext[BYTE_W-1:0];
        assign byte_cout[i] = ext[BYTE_W];
        // carry into the sign bit differs from carry out on signed overflow
        assign byte_ovf[i]  = ext[BYTE_W] ^ (ext[BYTE_W-1] ^ a_b[BYTE_W-1] ^ b_x[BYTE_W-1]);
        assign byte_aneg[i] = a_b[BYTE_W-1];
    end
endmodule

// File: rtl/psimd_satclamp.sv
module psimd_satclamp
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0]        sum,
    input  logic [DATA_W/BYTE_W-1:0] byte_cout,
    input  logic [DATA_W/BYTE_W-1:0] byte_ovf,
    input  logic [DATA_W/BYTE_W-1:0] byte_aneg,
    input  lane_sel_e                lane_sel,
    input  logic                     sub,
    input  logic                     sat,
    input  logic                     sat_signed,
    output logic [DATA_W-1:0]        res
);
    localparam int NB = DATA_W / BYTE_W;
    localparam logic [BYTE_W-1:0] ONES = {BYTE_W{1'b1}};
    localparam logic [BYTE_W-1:0] SMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] SMIN = {1'b1, {(BYTE_W-1){1'b0}}};

    for (genvar i = 0; i < NB; i++) begin : g_byte
        localparam int T16 = i | 1;
        localparam int T32 = i | 3;
        logic              cout_t, ovf_t, neg_t, top;
        logic              u_clip, s_clip;
        logic [BYTE_W-1:0] byte_d;

        // flags come from the most significant byte of the lane holding byte i
        always_comb begin
            case (lane_sel)
                LANE8: begin
                    cout_t = byte_cout[i];
                    ovf_t  = byte_ovf[i];
                    neg_t  = byte_aneg[i];
                    top    = 1'b1;
                end
                LANE16: begin
                    cout_t = byte_cout[T16];
                    ovf_t  = byte_ovf[T16];
                    neg_t  = byte_aneg[T16];
                    top    = (T16 == i);
                end
                default: begin
                    cout_t = byte_cout[T32];
                    ovf_t  = byte_ovf[T32];
                    neg_t  = byte_aneg[T32];
                    top    = (T32 == i);
                end
            endcase
        end

        always_comb begin
            u_clip = sat && !sat_signed && (sub ? !cout_t : cout_t);
            s_clip = sat && sat_signed && ovf_t;
            byte_d = sum[i*BYTE_W +: BYTE_W];
            if (u_clip) begin
                byte_d = sub ? '0 : ONES;
            end else if (s_clip) begin
                if (neg_t) byte_d = top ? SMIN : '0;
                else       byte_d = top ? SMAX : ONES;
            end
        end

        assign res[i*BYTE_W +: BYTE_W] = byte_d;
    end
endmodule

// File: rtl/psimd_alu.sv
module psimd_alu
    import psimd_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [1:0]        lane_sel_i,
    input  logic              sub_i,
    input  logic              sat_i,
    input  logic              sat_signed_i,
    output logic [DATA_W-1:0] res_o,
    output logic              out_valid_o
);
    localparam int NB = DATA_W / BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              vld;
    } state_t;

    state_t            st_d, st_q;
    lane_sel_e         lane_sel;
    logic [DATA_W-1:0] sum, lane_res;
    logic [NB-1:0]     byte_cout, byte_ovf, byte_aneg;

    assign lane_sel = lane_sel_e'(lane_sel_i);

    psimd_segadd #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_add (
        .a(a_i), .b(b_i), .lane_sel(lane_sel), .sub(sub_i),
        .sum(sum), .byte_cout(byte_cout), .byte_ovf(byte_ovf), .byte_aneg(byte_aneg)
    );

    psimd_satclamp #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_clamp (
        .sum(sum), .byte_cout(byte_cout), .byte_ovf(byte_ovf), .byte_aneg(byte_aneg),
        .lane_sel(lane_sel), .sub(sub_i), .sat(sat_i), .sat_signed(sat_signed_i),
        .res(lane_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.res = lane_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o       = st_q.res;
    assign out_valid_o = st_q.vld;

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid_o);
    // R9
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid_o);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_o));
    // R3
    low_byte_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_i && !sub_i) |=>
        res_o[BYTE_W-1:0] == $past(a_i[BYTE_W-1:0] + b_i[BYTE_W-1:0]));
    // R6
    usat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_i && !sat_signed_i && !sub_i && lane_sel_i == 2'd0) |=>
        res_o[BYTE_W-1:0] >= $past(a_i[BYTE_W-1:0]));
endmodule

// File: tb/sim_psimd_alu.sv
module sim_psimd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] a_i = '0, b_i = '0;
    logic [1:0]  lane_sel_i = '0;
    logic        sub_i = 1'b0, sat_i = 1'b0, sat_signed_i = 1'b0;
    logic [63:0] res_o;
    logic        out_valid_o;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    psimd_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_i(a_i), .b_i(b_i),
        .lane_sel_i(lane_sel_i), .sub_i(sub_i), .sat_i(sat_i),
        .sat_signed_i(sat_signed_i), .res_o(res_o), .out_valid_o(out_valid_o)
    );

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b,
                                          logic [1:0] ls, logic sb, logic st, logic sg);
        int          w = (ls == 2'd0) ? 8 : (ls == 2'd1) ? 16 : 32;
        longint      mask = (longint'(1) << w) - 1;
        longint      half = longint'(1) << (w - 1);
        logic [63:0] out = '0;
        for (int k = 0; k < 64 / w; k++) begin
            longint ua = longint'((a >> (k * w)) & 64'(mask));
            longint ub = longint'((b >> (k * w)) & 64'(mask));
            longint r;
            if (st && sg) begin
                longint sa = (ua >= half) ? ua - 2 * half : ua;
                longint sbv = (ub >= half) ? ub - 2 * half : ub;
                r = sb ? sa - sbv : sa + sbv;
                if (r > half - 1) r = half - 1;
                if (r < -half) r = -half;
            end else begin
                r = sb ? ua - ub : ua + ub;
                if (st && r > mask) r = mask;
                if (st && r < 0) r = 0;
            end
            out = out | (64'(r & mask) << (k * w));
        end
        return out;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // one strobed operation, then compare result and output strobe
    task automatic run_op(string tag, logic [63:0] a, logic [63:0] b,
                          logic [1:0] ls, logic sb, logic st, logic sg);
        @(negedge clk);
        a_i = a; b_i = b; lane_sel_i = ls; sub_i = sb; sat_i = st; sat_signed_i = sg;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, res_o, model(a, b, ls, sb, st, sg));
        check({tag, " R9 strobe"}, 64'(out_valid_o), 64'd1);
    endtask

    task automatic t_reset;
        check("R11 reset result", res_o, 64'd0);
        check("R11 reset strobe", 64'(out_valid_o), 64'd0);
    endtask

    task automatic t_widths;
        logic [63:0] x = 64'h0123_4567_89AB_CDEF;
        for (int ls = 0; ls < 4; ls++) begin
            run_op("R1 R3 wrap add", x, 64'hFEDC_BA98_7654_3210 ^ (x << ls), 2'(ls), 0, 0, 0);
            x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
        end
    endtask

    task automatic t_carry_cut;
        run_op("R2 byte cut", 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 0, 0, 0);
        check("R2 byte cut value", res_o, 64'h0000_0000_0000_0000);
        run_op("R2 half cut", 64'h00FF_FFFF_00FF_FFFF, 64'h0001_0001_0001_0001, 2'd1, 0, 0, 0);
        check("R2 half cut value", res_o, 64'h0100_0000_0100_0000);
        run_op("R2 word cut", 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd2, 0, 0, 0);
        check("R2 word cut value", res_o, 64'h0000_0000_0001_0000);
        run_op("R2 borrow cut", 64'h0, 64'h0000_0001_0000_0001, 2'd1, 1, 0, 0);
    endtask

    task automatic t_sub;
        run_op("R4 sub byte", 64'h1122_3344_5566_7788, 64'h8877_6655_4433_2211, 2'd0, 1, 0, 0);
        run_op("R4 sub word", 64'h0000_0005_FFFF_0000, 64'h0000_0006_0000_0001, 2'd3, 1, 0, 0);
    endtask

    task automatic t_signed_sat;
        run_op("R5 pos ovf byte", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0102_0304_0506_0708, 2'd0, 0, 1, 1);
        check("R5 pos ovf value", res_o, 64'h7F7F_7F7F_7F7F_7F7F);
        run_op("R5 neg ovf half", 64'h8000_8000_8000_8000, 64'h0001_0001_0001_0001, 2'd1, 1, 1, 1);
        check("R5 neg ovf value", res_o, 64'h8000_8000_8000_8000);
        run_op("R5 mixed word", 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 2'd2, 1, 1, 1);
        check("R5 mixed value", res_o, 64'h8000_0000_7FFF_FFFF);
    endtask

    task automatic t_unsigned_sat;
        run_op("R6 add clamp half", 64'hFFF0_0010_8000_0001, 64'h0020_0010_8000_FFFF, 2'd1, 0, 1, 0);
        check("R6 add clamp value", res_o, 64'hFFFF_0020_FFFF_FFFF);
        run_op("R7 sub clamp byte", 64'h0510_FF00_0102_0304, 64'h0605_0001_0201_0403, 2'd0, 1, 1, 0);
        check("R7 sub clamp value", res_o, 64'h000B_FF00_0001_0001);
    endtask

    task automatic t_sat_quiet;
        run_op("R8 signed no ovf", 64'h1020_3040_F0E0_D0C0, 64'h0101_0101_0101_0101, 2'd0, 0, 1, 1);
        check("R8 signed match", res_o, model(64'h1020_3040_F0E0_D0C0, 64'h0101_0101_0101_0101, 0, 0, 0, 0));
        run_op("R8 unsigned no ovf", 64'h0000_1000_0000_2000, 64'h0000_0100_0000_0200, 2'd2, 1, 1, 0);
        check("R8 unsigned match", res_o, 64'h0000_0F00_0000_1E00);
    endtask

    task automatic t_hold;
        logic [63:0] kept = res_o;
        @(negedge clk);
        a_i = 64'hDEAD_BEEF_0BAD_F00D; b_i = 64'h1234_5678_9ABC_DEF0; sat_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 hold result", res_o, kept);
        check("R9 idle strobe", 64'(out_valid_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_widths();
        t_carry_cut();
        t_sub();
        t_signed_sat();
        t_unsigned_sat();
        t_sat_quiet();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule